// File: doc/BRIEF.md
# Per-Bit Configurable Interrupt Controller

This block gathers event inputs from two groups of up to eight sources each into two interrupt status registers. It drives a single interrupt pin from them. For each status bit, the sensitivity is set by two separate mode registers: a high-select register and a low-select register. Together they choose rising-edge, falling-edge or level behaviour. Each status register has its own mask register. The interrupt is active when any status bit is set and its mask bit is also set.

Event inputs may be asynchronous. They pass through a synchroniser before any edge is detected. Edge-sensitive bits latch and stay set until software reads their status register. Level-sensitive bits follow the synchronised input directly.

The pin stage is programmable. It can drive active-high, drive active-low, or act as an open-drain style output. In open-drain style the block only asserts an output-enable to pull the line low, and never drives a high level. Software reaches all state through a single synchronous read and write port, and reading a status register clears it.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, every status, mask and mode register reads 0. The pin style field reads 0. The pin outputs are `irq_o`=0 and `irq_oe`=1.
- R2: For each bit, the pair (high-select bit, low-select bit) selects the sensitivity: 00 is rising edge, 01 is falling edge, 10 is level, and 11 also behaves as level.
- R3: An edge-mode bit sets when its selected edge appears on the synchronised input. The opposite edge does not set it. Once set, it stays set until its status register is read.
- R4: Reading a status register (`rd_en`=1 at its address) returns its value and clears its edge-mode bits at that clock edge. If an edge is detected in the same cycle as the read, that bit stays set.
- R5: A level-mode bit shows the current synchronised input. Reading does not clear it while the input stays high. It returns to 0 when the input falls.
- R6: Only defined bits can ever read as 1. In status register A these are bits 0, 1, 2, 6 and 7 (0xC7). In status register B these are bits 1, 2 and 3 (0x0E). All other bits read as 0.
- R7: The interrupt is active exactly when at least one status bit of either register is 1 and its mask bit is 1.
- R8: The pin style field is bits [1:0] at address 8. Value 0 gives `irq_oe`=1 and `irq_o`=active. Value 1 gives `irq_oe`=1 and `irq_o`=not active. Values 2 and 3 give `irq_o`=0 and `irq_oe`=active.
- R9: An input change made before clock edge k is seen in a level-mode status bit after edge k+1 and in an edge-mode bit after edge k+2. The pin reflects a status change one edge after the status changes.
- R10: The register map is as follows. Address 0 is status A and address 1 is status B. Addresses 2 and 3 are mask A and mask B. Addresses 4 and 5 are high-select A and low-select A. Addresses 6 and 7 are high-select B and low-select B. Address 8 is the pin style. Mask and mode registers read back all 8 written bits. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_a | input | 8 | Event inputs for status register A (asynchronous) |
| evt_b | input | 8 | Event inputs for status register B (asynchronous) |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; clears the addressed status register |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| irq_o | output | 1 | Interrupt pin data |
| irq_oe | output | 1 | Interrupt pin output-enable |

## Verification
The assertions check three things on every cycle. First, a selected edge always lands in the latched status. Second, a latched edge bit is never lost unless a read clears it. Third, a read clears only the bits that were not re-set in that same cycle. At the pin, they check that a released line never carries a high level and that the push-pull styles always drive.

Other behaviours can only be shown by the bench's scenarios. These are the full sensitivity encoding, including the reserved pair, the masking of undefined bits, and the exact cycle latency. They also include the race between a read and a coincident edge, and how each pin style responds as the interrupt is raised and dropped.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_STAT_A  = 4'd0,
    RA_STAT_B  = 4'd1,
    RA_MASK_A  = 4'd2,
    RA_MASK_B  = 4'd3,
    RA_HSEL_A  = 4'd4,
    RA_LSEL_A  = 4'd5,
    RA_HSEL_B  = 4'd6,
    RA_LSEL_B  = 4'd7,
    RA_PINSTY  = 4'd8
  } reg_addr_e;

  typedef enum logic [1:0] {
    PIN_DRIVE_HI  = 2'd0,
    PIN_DRIVE_LO  = 2'd1,
    PIN_OPEN_LO   = 2'd2,
    PIN_OPEN_ALT  = 2'd3
  } pin_style_e;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/irqc_evt_sync.sv
module irqc_evt_sync #(
  parameter int unsigned DW     = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_in,
  output logic [DW-1:0] lvl,
  output logic [DW-1:0] rise,
  output logic [DW-1:0] fall
);
  logic [STAGES-1:0][DW-1:0] pipe_q, pipe_d;
  logic [DW-1:0]             prev_q;

  always_comb begin
    pipe_d[0] = evt_in;
    for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      prev_q <= '0;
    end else begin
      pipe_q <= pipe_d;
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign lvl  = pipe_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int unsigned    DW    = 8,
  parameter logic [DW-1:0]  VALID = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] lvl,
  input  logic [DW-1:0] rise,
  input  logic [DW-1:0] fall,
  input  logic          wr_mask,
  input  logic          wr_hsel,
  input  logic          wr_lsel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clr,
  output logic [DW-1:0] stat,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] hsel_q,
  output logic [DW-1:0] lsel_q,
  output logic          hit
);
  logic [DW-1:0] latch_q, latch_d;
  logic [DW-1:0] mask_d, hsel_d, lsel_d;
  logic [DW-1:0] set_v;

  // Next-state logic
  always_comb begin
    mask_d  = wr_mask ? wr_data : mask_q;
    hsel_d  = wr_hsel ? wr_data : hsel_q;
    lsel_d  = wr_lsel ? wr_data : lsel_q;
    // low-select picks falling edge, high-select overrides to level
    set_v   = ((rise & ~lsel_q) | (fall & lsel_q)) & ~hsel_q & VALID;
    latch_d = rd_clr ? set_v : (latch_q | set_v);
    latch_d = latch_d & ~hsel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      mask_q  <= '0;
      hsel_q  <= '0;
      lsel_q  <= '0;
    end else begin
      latch_q <= latch_d;
      mask_q  <= mask_d;
      hsel_q  <= hsel_d;
      lsel_q  <= lsel_d;
    end
  end

  assign stat = ((hsel_q & lvl) | (~hsel_q & latch_q)) & VALID;
  assign hit  = |(stat & mask_q);

  // R3: a detected selected edge is always captured
  p_edge_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((latch_q & $past(set_v)) == $past(set_v)));

  // R3: latched edge bits survive when no read happens
  p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((latch_q & $past(latch_q & ~hsel_q)) == $past(latch_q & ~hsel_q)));

  // R4: a read leaves only the bits re-set in the same cycle
  p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((latch_q & ~$past(set_v)) == '0));
endmodule

// File: rtl/irqc_pin_drv.sv
module irqc_pin_drv
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act,
  input  pin_style_e style,
  output logic       irq_o,
  output logic       irq_oe
);
  logic o_d, oe_d;

  always_comb begin
    unique case (style)
      PIN_DRIVE_HI: begin o_d = act;  oe_d = 1'b1; end
      PIN_DRIVE_LO: begin o_d = ~act; oe_d = 1'b1; end
      default:      begin o_d = 1'b0; oe_d = act;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      irq_oe <= 1'b1;
    end else begin
      irq_o  <= o_d;
      irq_oe <= oe_d;
    end
  end

  // R8: a released line never carries a driven high level
  p_release_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_oe |-> !irq_o);

  // R8: push-pull styles always drive the line
  p_push_pull_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (style == PIN_DRIVE_HI || style == PIN_DRIVE_LO) |=> irq_oe);
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned   DW          = 8,
  parameter int unsigned   SYNC_STAGES = 2,
  parameter logic [DW-1:0] VALID_A     = 8'hC7,
  parameter logic [DW-1:0] VALID_B     = 8'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     evt_a,
  input  logic [DW-1:0]     evt_b,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  output logic              irq_o,
  output logic              irq_oe
);
  localparam int unsigned NB = 2;
  localparam logic [NB-1:0][DW-1:0] VALID_ALL = {VALID_B, VALID_A};

  logic                   rst_sn;
  logic [NB-1:0][DW-1:0]  evt_all;
  logic [NB-1:0][DW-1:0]  rd_part;
  logic [NB-1:0]          hit;
  pin_style_e             style_q, style_d;
  logic                   act;

  assign evt_all = {evt_b, evt_a};

  irqc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  for (genvar g = 0; g < NB; g++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(g);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(2 + g);
    localparam logic [ADDR_W-1:0] A_HSEL = ADDR_W'(4 + 2*g);
    localparam logic [ADDR_W-1:0] A_LSEL = ADDR_W'(5 + 2*g);

    logic [DW-1:0] lvl, rise, fall, stat, mask_q, hsel_q, lsel_q;

    irqc_evt_sync #(.DW(DW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_sn), .evt_in(evt_all[g]),
      .lvl(lvl), .rise(rise), .fall(fall)
    );

    irqc_bank #(.DW(DW), .VALID(VALID_ALL[g])) u_bank (
      .clk(clk), .rst_n(rst_sn),
      .lvl(lvl), .rise(rise), .fall(fall),
      .wr_mask(wr_en && addr == A_MASK),
      .wr_hsel(wr_en && addr == A_HSEL),
      .wr_lsel(wr_en && addr == A_LSEL),
      .wr_data(wr_data),
      .rd_clr(rd_en && addr == A_STAT),
      .stat(stat), .mask_q(mask_q), .hsel_q(hsel_q), .lsel_q(lsel_q),
      .hit(hit[g])
    );

    always_comb begin
      unique case (addr)
        A_STAT:  rd_part[g] = stat;
        A_MASK:  rd_part[g] = mask_q;
        A_HSEL:  rd_part[g] = hsel_q;
        A_LSEL:  rd_part[g] = lsel_q;
        default: rd_part[g] = '0;
      endcase
    end
  end

  // Pin style register
  always_comb begin
    style_d = style_q;
    if (wr_en && addr == RA_PINSTY) style_d = pin_style_e'(wr_data[1:0]);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) style_q <= PIN_DRIVE_HI;
    else         style_q <= style_d;
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NB; b++) rd_data = rd_data | rd_part[b];
    if (addr == RA_PINSTY) rd_data = rd_data | DW'(style_q);
  end

  assign act = |hit;

  irqc_pin_drv u_pin (
    .clk(clk), .rst_n(rst_sn), .act(act), .style(style_q),
    .irq_o(irq_o), .irq_oe(irq_oe)
  );

  // R7: a masked-in set bit of either register brings the line active next cycle
  p_active_follows_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (act && style_q == PIN_DRIVE_HI && !wr_en) |=> irq_o);
endmodule

// File: tb/sim_evt_irq_ctrl.sv
module sim_evt_irq_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] evt_a, evt_b, wr_data, rd_data;
  logic [3:0] addr;
  logic       wr_en, rd_en, irq_o, irq_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt_a(evt_a), .evt_b(evt_b),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  // {hsel, lsel, mask, evt first, evt second, expected status, expected irq}
  localparam logic [48:0] VECS [8] = '{
    {8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'hC7, 1'b1},  // R2 R3 rising
    {8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hC7, 1'b1},  // R2 R3 falling
    {8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b0},  // R3 opposite edge
    {8'hFF, 8'h00, 8'hFF, 8'h00, 8'h05, 8'h05, 1'b1},  // R5 level
    {8'hFF, 8'hFF, 8'h00, 8'h00, 8'hC0, 8'hC0, 1'b0},  // R2 reserved pair, masked
    {8'h01, 8'h02, 8'h02, 8'h02, 8'hC5, 8'hC7, 1'b1},  // R2 mixed modes
    {8'h00, 8'h00, 8'hFF, 8'h00, 8'h38, 8'h00, 1'b0},  // R6 undefined bits
    {8'h00, 8'h00, 8'hBF, 8'h00, 8'h40, 8'h40, 1'b0}   // R7 mask gating
  };

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; evt_a = '0; evt_b = '0; addr = '0;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 irq_o", {7'd0, irq_o}, 8'h00);
    chk("R1 irq_oe", {7'd0, irq_oe}, 8'h01);
    peek(4'd0, d); chk("R1 status A", d, 8'h00);
    peek(4'd2, d); chk("R1 mask A", d, 8'h00);
    peek(4'd8, d); chk("R1 pin style", d, 8'h00);

    // Vector table: R2 R3 R5 R6 R7
    foreach (VECS[i]) begin
      logic [48:0] v;
      v = VECS[i];
      wr(4'd4, v[48:41]);
      wr(4'd5, v[40:33]);
      wr(4'd2, v[32:25]);
      @(negedge clk); evt_a = v[24:17];
      idle(5);
      rd(4'd0, d);
      @(negedge clk); evt_a = v[16:9];
      idle(5);
      chk($sformatf("R7 vec%0d irq", i), {7'd0, irq_o}, {7'd0, v[0]});
      rd(4'd0, d);
      chk($sformatf("R2 vec%0d status", i), d, v[8:1]);
    end

    // R10 register map readback
    wr(4'd3, 8'hA5); peek(4'd3, d); chk("R10 mask B", d, 8'hA5);
    wr(4'd6, 8'h3C); peek(4'd6, d); chk("R10 hsel B", d, 8'h3C);
    wr(4'd7, 8'hF0); peek(4'd7, d); chk("R10 lsel B", d, 8'hF0);
    peek(4'd15, d); chk("R10 unmapped", d, 8'h00);
    wr(4'd8, 8'hFF); peek(4'd8, d); chk("R10 style bits", d, 8'h03);
    wr(4'd8, 8'h00);

    // R6 R7 register B alone: rising on all, mask bit 1
    wr(4'd6, 8'h00); wr(4'd7, 8'h00); wr(4'd3, 8'h02);
    wr(4'd2, 8'h00); evt_a = '0; idle(4); rd(4'd0, d);
    @(negedge clk); evt_b = 8'hFF; idle(5);
    chk("R7 bank B irq", {7'd0, irq_o}, 8'h01);
    rd(4'd1, d); chk("R6 status B defined", d, 8'h0E);
    idle(3);
    chk("R4 irq after clear", {7'd0, irq_o}, 8'h00);
    evt_b = '0; wr(4'd3, 8'h00); idle(4); rd(4'd1, d);

    // R4 read clears, second read sees zero
    wr(4'd4, 8'h00); wr(4'd5, 8'h00); wr(4'd2, 8'h01);
    @(negedge clk); evt_a = 8'h01; idle(5);
    @(negedge clk); evt_a = 8'h00; idle(5);
    rd(4'd0, d); chk("R4 first read", d, 8'h01);
    rd(4'd0, d); chk("R4 second read", d, 8'h00);

    // R4 edge coincident with read keeps the bit
    @(negedge clk); evt_a = 8'h01; idle(5);
    @(negedge clk); evt_a = 8'h00; idle(5);
    @(negedge clk); evt_a = 8'h01;
    @(negedge clk);
    @(negedge clk); addr = 4'd0; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    peek(4'd0, d); chk("R4 coincident edge kept", d, 8'h01);
    rd(4'd0, d);
    @(negedge clk); evt_a = 8'h00; idle(5); rd(4'd0, d);

    // R9 latency, level mode bit 0
    wr(4'd4, 8'h01); idle(2);
    @(negedge clk); evt_a = 8'h01;
    @(negedge clk); peek(4'd0, d); chk("R9 not yet after k", d, 8'h00);
    @(negedge clk); peek(4'd0, d); chk("R9 level after k+1", d, 8'h01);
    chk("R9 pin not yet", {7'd0, irq_o}, 8'h00);
    @(negedge clk); chk("R9 pin after k+2", {7'd0, irq_o}, 8'h01);

    // R5 level not cleared by reads
    rd(4'd0, d); chk("R5 read1", d, 8'h01);
    rd(4'd0, d); chk("R5 read2", d, 8'h01);

    // R8 pin styles while active
    wr(4'd8, 8'h01); idle(2);
    chk("R8 low o act", {7'd0, irq_o}, 8'h00); chk("R8 low oe act", {7'd0, irq_oe}, 8'h01);
    wr(4'd8, 8'h02); idle(2);
    chk("R8 od o act", {7'd0, irq_o}, 8'h00); chk("R8 od oe act", {7'd0, irq_oe}, 8'h01);
    wr(4'd8, 8'h03); idle(2);
    chk("R8 alt oe act", {7'd0, irq_oe}, 8'h01);
    @(negedge clk); evt_a = 8'h00; idle(5);
    peek(4'd0, d); chk("R5 drops with input", d, 8'h00);
    chk("R8 alt oe idle", {7'd0, irq_oe}, 8'h00);
    chk("R8 alt o idle", {7'd0, irq_o}, 8'h00);
    wr(4'd8, 8'h02); idle(2);
    chk("R8 od oe idle", {7'd0, irq_oe}, 8'h00);
    wr(4'd8, 8'h01); idle(2);
    chk("R8 low o idle", {7'd0, irq_o}, 8'h01); chk("R8 low oe idle", {7'd0, irq_oe}, 8'h01);

    finish_run();
  end
endmodule